// File: doc/BRIEF.md
# Four-Lane Idle-Column Rate Matcher

This block sits in the receive path of a four-lane 10 Gb attachment unit interface. Each lane hands over one byte and one control flag per recovered-clock cycle, and the four words of a cycle form a column. The columns are written into a shared elastic buffer in the recovered-clock domain and read out in the local core-clock domain. The two clocks are nominally equal but drift apart by a small amount, so the block absorbs the difference. It drops idle columns when the buffer runs too full and repeats them when it runs too empty.

Only a column in which all four lanes carry the idle character /R/ (control code K28.0) can be dropped or repeated. Any column holding data, another control character, or only some /R/ words passes through unchanged and in order. The write and read pointers cross between the domains as Gray code through two-flop synchronizers. Each side works out its own view of the occupancy. Status pulses report when the buffer still overflows or runs dry even with this compensation.

Top module: `xaui_colrm`

## Requirements
- R1: Every column that is not an idle column leaves the read side unchanged, with none missing, none repeated and in the order it was written, as long as no overflow occurs.
- R2: An idle column has, in all four lanes, data 0x1C with the control flag 1. Lane i uses data bits [8i+7:8i] and ctrl bit i. A column with any lane different from this is treated as data.
- R3: When the write-side occupancy is above 12 columns and the incoming column is idle, that column is not stored. With idle columns present, this keeps a faster writer from overflowing the 16-column buffer.
- R4: When the read-side occupancy is below 4 columns and the column at the head is idle, that column is emitted twice. It is never emitted more than twice, so a slower writer does not cause underflow.
- R5: A column that holds /R/ in only some of its lanes is never dropped or repeated.
- R6: After reset, the read side emits idle columns and reports no underflow until at least 8 columns are buffered.
- R7: When the buffer is full and the incoming column is not being deleted, the column is dropped and wr_overflow is 1 for that cycle.
- R8: Once primed, if the read side finds the buffer empty, it emits an idle column and rd_underflow is 1 for that cycle.
- R9: The Gray-coded pointer sent across each clock domain changes by at most one bit per source cycle.
- R10: While in reset, rd_data/rd_ctrl present an idle column, and wr_overflow and rd_underflow are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst_n | input | 1 | Active-low reset, write domain |
| wr_data | input | 32 | Four lane bytes, lane 0 in the low byte |
| wr_ctrl | input | 4 | Control flag per lane |
| wr_overflow | output | 1 | Column dropped because the buffer was full |
| rd_clk | input | 1 | Local core clock |
| rd_rst_n | input | 1 | Active-low reset, read domain |
| rd_data | output | 32 | Four lane bytes out |
| rd_ctrl | output | 4 | Control flag per lane out |
| rd_underflow | output | 1 | Buffer found empty after priming |

## Verification
The column stream is a random mix of idle columns, data columns, non-idle control columns, and columns where only one lane breaks the idle pattern. The read output is compared against the written stream with idle columns removed. Running at equal rates, with a slower reader, and with a faster reader shows whether the block deletes idle columns, repeats them, or leaves them alone. The slower-reader run must show fewer idle columns out than in, and the faster-reader run more, with each idle column repeated no more than once. The partial-idle columns show whether the idle match checks all four lanes. Data-only streams with a clearly faster or slower reader force underflow and overflow. In the underflow case the data still comes out intact.

// File: rtl/xrm_pkg.sv
`timescale 1ns/1ps
package xrm_pkg;
    localparam int LANE_N = 4;
    localparam int LANE_W = 8;
    localparam logic [LANE_W-1:0] IDLE_CHAR = 8'h1C;

    typedef struct packed {
        logic              k;
        logic [LANE_W-1:0] d;
    } lane_t;

    typedef lane_t [LANE_N-1:0] col_t;

    localparam col_t IDLE_COL = {LANE_N{{1'b1, IDLE_CHAR}}};
endpackage

// File: rtl/xrm_col_detect.sv
`timescale 1ns/1ps
module xrm_col_detect
    import xrm_pkg::*;
(
    input  col_t col_i,
    output logic idle_o
);
    logic [LANE_N-1:0] lane_hit;

    for (genvar g = 0; g < LANE_N; g++) begin : g_lane
        assign lane_hit[g] = col_i[g].k && (col_i[g].d == IDLE_CHAR);
    end

    assign idle_o = &lane_hit;
endmodule

// File: rtl/xrm_ptr_sync.sv
`timescale 1ns/1ps
module xrm_ptr_sync #(
    parameter int PW = 5
) (
    input  logic          src_clk,
    input  logic          src_rst_n,
    input  logic [PW-1:0] src_bin,
    input  logic          dst_clk,
    input  logic          dst_rst_n,
    output logic [PW-1:0] dst_bin
);
    logic [PW-1:0] gray_q, meta_q, sync_q;
    logic [PW-1:0] bin_c;

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) gray_q <= '0;
        else            gray_q <= src_bin ^ (src_bin >> 1);
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_q;
            sync_q <= meta_q;
        end
    end

    always_comb begin
        bin_c[PW-1] = sync_q[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            bin_c[i] = bin_c[i+1] ^ sync_q[i];
        end
    end

    assign dst_bin = bin_c;

    AST_GRAY_ONE_BIT: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        src_rst_n |=> ($countones(gray_q ^ $past(gray_q)) <= 1)); // R9
endmodule

// File: rtl/xaui_colrm.sv
`timescale 1ns/1ps
module xaui_colrm
    import xrm_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DEL_TH = 12,
    parameter int INS_TH = 4,
    parameter int PRIME  = 8
) (
    input  logic                     wr_clk,
    input  logic                     wr_rst_n,
    input  logic [LANE_N*LANE_W-1:0] wr_data,
    input  logic [LANE_N-1:0]        wr_ctrl,
    output logic                     wr_overflow,
    input  logic                     rd_clk,
    input  logic                     rd_rst_n,
    output logic [LANE_N*LANE_W-1:0] rd_data,
    output logic [LANE_N-1:0]        rd_ctrl,
    output logic                     rd_underflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic          ovf;
    } wr_st_t;

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic          primed;
        logic          rep;
        logic          unf;
        col_t          out;
    } rd_st_t;

    localparam rd_st_t RD_INIT = '{ptr: '0, primed: 1'b0, rep: 1'b0, unf: 1'b0, out: IDLE_COL};

    col_t          mem_q [DEPTH];
    col_t          in_col, head_col;
    logic          in_idle, head_idle;
    wr_st_t        wr_q, wr_d;
    rd_st_t        rd_q, rd_d;
    logic          wr_we;
    logic [PW-1:0] rd_ptr_w, wr_ptr_r, occ_w, occ_r;

    for (genvar g = 0; g < LANE_N; g++) begin : g_map
        assign in_col[g].k                = wr_ctrl[g];
        assign in_col[g].d                = wr_data[g*LANE_W +: LANE_W];
        assign rd_ctrl[g]                 = rd_q.out[g].k;
        assign rd_data[g*LANE_W +: LANE_W] = rd_q.out[g].d;
    end

    xrm_col_detect u_det_wr (.col_i(in_col),   .idle_o(in_idle));
    xrm_col_detect u_det_rd (.col_i(head_col), .idle_o(head_idle));

    xrm_ptr_sync #(.PW(PW)) u_sync_w2r (
        .src_clk(wr_clk), .src_rst_n(wr_rst_n), .src_bin(wr_q.ptr),
        .dst_clk(rd_clk), .dst_rst_n(rd_rst_n), .dst_bin(wr_ptr_r)
    );
    xrm_ptr_sync #(.PW(PW)) u_sync_r2w (
        .src_clk(rd_clk), .src_rst_n(rd_rst_n), .src_bin(rd_q.ptr),
        .dst_clk(wr_clk), .dst_rst_n(wr_rst_n), .dst_bin(rd_ptr_w)
    );

    // ---------------- write domain ----------------
    assign occ_w = wr_q.ptr - rd_ptr_w;

    always_comb begin
        wr_d     = wr_q;
        wr_d.ovf = 1'b0;
        wr_we    = 1'b0;
        if (in_idle && (occ_w > PW'(DEL_TH))) begin
            wr_we = 1'b0;                 // idle column deleted
        end else if (occ_w == PW'(DEPTH)) begin
            wr_d.ovf = 1'b1;              // full: column lost
        end else begin
            wr_we     = 1'b1;
            wr_d.ptr  = wr_q.ptr + PW'(1);
        end
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) wr_q <= '0;
        else           wr_q <= wr_d;
    end

    always_ff @(posedge wr_clk) begin
        if (wr_we) mem_q[wr_q.ptr[AW-1:0]] <= in_col;
    end

    assign wr_overflow = wr_q.ovf;

    AST_NO_WRITE_WHEN_FULL: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (occ_w == PW'(DEPTH)) |=> (wr_q.ptr == $past(wr_q.ptr))); // R7
    AST_DATA_KEPT: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (!in_idle) |=> ((wr_q.ptr != $past(wr_q.ptr)) || wr_q.ovf)); // R1

    // ---------------- read domain ----------------
    assign occ_r    = wr_ptr_r - rd_q.ptr;
    assign head_col = mem_q[rd_q.ptr[AW-1:0]];

    always_comb begin
        rd_d     = rd_q;
        rd_d.unf = 1'b0;
        if (!rd_q.primed) begin
            rd_d.out = IDLE_COL;
            if (occ_r >= PW'(PRIME)) rd_d.primed = 1'b1;
        end else if (occ_r == '0) begin
            rd_d.out = IDLE_COL;
            rd_d.unf = 1'b1;
            rd_d.rep = 1'b0;
        end else if (head_idle && (occ_r < PW'(INS_TH)) && !rd_q.rep) begin
            rd_d.out = head_col;          // emit, hold pointer: repeat next
            rd_d.rep = 1'b1;
        end else begin
            rd_d.out = head_col;
            rd_d.ptr = rd_q.ptr + PW'(1);
            rd_d.rep = 1'b0;
        end
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) rd_q <= RD_INIT;
        else           rd_q <= rd_d;
    end

    assign rd_underflow = rd_q.unf;

    AST_INS_ONCE: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_q.rep |=> !rd_q.rep); // R4
    AST_UNDERFLOW_IDLE: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_q.unf |-> (rd_q.out == IDLE_COL)); // R8
    AST_PRIME_IDLE: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !rd_q.primed |=> ((rd_q.out == IDLE_COL) && !rd_q.unf)); // R6
    AST_RD_STEP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_q.primed |=> ((rd_q.ptr - $past(rd_q.ptr)) <= PW'(1))); // R1
endmodule

// File: tb/xaui_colrm_bench.sv
`timescale 1ns/1ps
module xaui_colrm_bench;
    localparam real CLK_PERIOD = 10.0;
    localparam logic [35:0] IDLE_C = {4{1'b1, 8'h1C}};

    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic [31:0] wr_data, rd_data;
    logic [3:0]  wr_ctrl, rd_ctrl;
    logic        wr_overflow, rd_underflow;
    real         rd_half = CLK_PERIOD / 2.0;

    int n_chk = 0, n_fail = 0;
    int wr_idle = 0, rd_idle = 0, ovf_cnt = 0, unf_cnt = 0;
    int cmp_cnt = 0, part_cnt = 0, rd_since_rst = 0;
    bit sb_on = 1'b0, finished = 1'b0;
    logic [35:0] sbq[$];

    xaui_colrm u_xaui_colrm (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_data(wr_data), .wr_ctrl(wr_ctrl),
        .wr_overflow(wr_overflow), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
        .rd_data(rd_data), .rd_ctrl(rd_ctrl), .rd_underflow(rd_underflow)
    );

    always #(CLK_PERIOD / 2.0) wr_clk = ~wr_clk;
    always #(rd_half) rd_clk = ~rd_clk;

    // pack {ctrl[3:0], data[31:0]} as 9 bits per lane: {k,d} lane3..lane0
    function automatic logic [35:0] pack(input logic [3:0] c, input logic [31:0] d);
        logic [35:0] r;
        for (int i = 0; i < 4; i++) r[i*9 +: 9] = {c[i], d[i*8 +: 8]};
        return r;
    endfunction

    function automatic bit is_idle(input logic [35:0] col);
        return col == IDLE_C;
    endfunction

    // mode 0: mixed, mode 1: never idle
    function automatic logic [35:0] gen_col(input int mode, output bit partial);
        int r = $urandom % 10;
        logic [35:0] c;
        int ln;
        partial = 1'b0;
        if (mode == 1 && r < 4) r = 4 + ($urandom % 6);
        if (r < 4) c = IDLE_C;
        else if (r < 8) c = pack(4'h0, $urandom);
        else if (r == 8) begin
            c = IDLE_C;
            ln = $urandom % 4;
            c[ln*9 +: 9] = ($urandom % 2) ? {1'b0, 8'h1C} : {1'b1, 8'hBC};
            partial = 1'b1;
        end else c = pack(4'hF, {4{8'h7C}});
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_idle();
        wr_data = 32'h1C1C1C1C;
        wr_ctrl = 4'hF;
    endtask

    task automatic run_cols(input int n, input int mode);
        logic [35:0] c;
        bit part;
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            c = gen_col(mode, part);
            for (int l = 0; l < 4; l++) begin
                wr_ctrl[l]       = c[l*9 + 8];
                wr_data[l*8 +: 8] = c[l*9 +: 8];
            end
            if (is_idle(c)) wr_idle++;
            else if (sb_on) sbq.push_back(c);
        end
    endtask

    task automatic do_reset();
        sb_on = 1'b0;
        @(negedge wr_clk);
        drive_idle();
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        repeat (4) @(negedge wr_clk);
        check(pack(rd_ctrl, rd_data) == IDLE_C, "R10 idle out in reset", pack(rd_ctrl, rd_data), IDLE_C);
        check({wr_overflow, rd_underflow} == 2'b00, "R10 flags in reset", {34'd0, wr_overflow, rd_underflow}, 36'd0);
        sbq.delete();
        rd_since_rst = 0;
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        sb_on = 1'b1;
    endtask

    task automatic clear_cnt();
        wr_idle = 0; rd_idle = 0; ovf_cnt = 0; unf_cnt = 0;
    endtask

    always @(negedge wr_clk) if (wr_rst_n && wr_overflow) ovf_cnt++;

    always @(negedge rd_clk) begin
        logic [35:0] got, exp;
        if (rd_rst_n) begin
            got = pack(rd_ctrl, rd_data);
            rd_since_rst++;
            if (rd_since_rst <= 4) begin
                check(is_idle(got) && !rd_underflow, "R6 priming idle", got, IDLE_C);
            end
            if (rd_underflow) begin
                unf_cnt++;
                check(is_idle(got), "R8 idle on underflow", got, IDLE_C);
            end
            if (is_idle(got)) rd_idle++;
            else if (sb_on) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R1 unexpected column", got, 36'd0);
                end else begin
                    exp = sbq.pop_front();
                    cmp_cnt++;
                    if (exp[8] ^ exp[17] ^ exp[26] ^ exp[35] || exp[35:0] != {4{exp[8:0]}}) begin
                        // column whose lanes differ from each other: partial idle or data
                    end
                    if (is_partial(exp)) begin
                        part_cnt++;
                        check(got == exp, "R5 R2 partial idle column", got, exp);
                    end else begin
                        check(got == exp, "R1 column order/content", got, exp);
                    end
                end
            end
        end
    end

    function automatic bit is_partial(input logic [35:0] c);
        int hits = 0;
        for (int l = 0; l < 4; l++) if (c[l*9 +: 9] == {1'b1, 8'h1C}) hits++;
        return hits == 3;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        drive_idle();
        do_reset();

        // equal rates
        clear_cnt();
        run_cols(1500, 0);
        check(ovf_cnt == 0 && unf_cnt == 0, "R3 R4 equal rates no flags", 36'(ovf_cnt), 36'(unf_cnt));

        // slower reader: deletions needed
        rd_half = 10.6 / 2.0;
        clear_cnt();
        run_cols(3000, 0);
        check(ovf_cnt == 0, "R3 no overflow with slow reader", 36'(ovf_cnt), 36'd0);
        check(rd_idle < wr_idle - 40, "R3 idle columns deleted", 36'(rd_idle), 36'(wr_idle));

        // faster reader: insertions needed
        rd_half = 9.4 / 2.0;
        clear_cnt();
        run_cols(3000, 0);
        check(unf_cnt == 0, "R4 no underflow with fast reader", 36'(unf_cnt), 36'd0);
        check(rd_idle > wr_idle + 40, "R4 idle columns repeated", 36'(rd_idle), 36'(wr_idle));
        check(rd_idle <= 2 * wr_idle + 16, "R4 at most one repeat", 36'(rd_idle), 36'(2 * wr_idle));

        // fast reader, no idles: underflow, data still intact
        rd_half = 9.0 / 2.0;
        clear_cnt();
        run_cols(1500, 1);
        check(unf_cnt > 0, "R8 underflow reported", 36'(unf_cnt), 36'd1);
        check(cmp_cnt > 4000, "R1 R9 columns compared across domains", 36'(cmp_cnt), 36'd4000);
        check(part_cnt > 100, "R5 partial columns passed", 36'(part_cnt), 36'd100);

        // slow reader, no idles: overflow
        do_reset();
        sb_on = 1'b0;
        rd_half = 11.0 / 2.0;
        clear_cnt();
        run_cols(1500, 1);
        check(ovf_cnt > 0, "R7 overflow reported", 36'(ovf_cnt), 36'd1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule